// File: doc/BRIEF.md
# SATA PHY Lane Override Sequencer

This block applies the per-lane receive and transmit overrides that a SATA PHY needs after a link hard reset. It reaches the PHY only through an indirect register engine. It issues single read or write requests and waits for each one to be acknowledged. For the override command it first waits until the lane leaves half-rate, with a bounded number of polls. It then forces the receive DPLL into a fixed mode and pulses that DPLL's reset. After a settling delay it may also force the transmit attenuation. A separate command clears the receive override only.

A third command runs the whole retry loop. Each attempt clears the receive override, requests a hard reset from an external agent, and then applies the overrides again. The loop ends when the link reports online, when no device is present, or when the retry budget is spent. If a lane has no PHY mapped, no register access is made; the hard-reset requests of the retry loop still go out.

Top module: `phy_lane_seq`

## Requirements
- R1: After reset, reg_req, hr_req, busy and done are all low.
- R2: Every access holds reg_req high with reg_addr, reg_we and reg_wdata stable until the cycle in which reg_ack is seen. Read data is taken from reg_rdata in that cycle.
- R3: The override command first reads the RX status word at 0x2002 + lane*0x100. It repeats this read while bit 0 (half-rate) reads as 1, up to POLL_MAX reads in total, and then goes on whatever the last value was.
- R4: After polling, the RX status is read once more as value S. Five writes to RX override at 0x2005 + lane*0x100 follow, in this order: S with bit 14 cleared; the same with bit 14 set; the same with bits 10:8 replaced by DPLL_MODE (3); the same with bit 11 set; the same with bit 11 cleared.
- R5: After the last RX override write, no access is issued for at least SETTLE_CYC cycles.
- R6: When atten bit 3 is 0, the TX status at 0x2001 + lane*0x100 is read as T. Three writes to TX override at 0x2004 + lane*0x100 follow: T with bit 15 cleared; the same with bit 15 set; the same with atten[2:0] OR-ed into bits 12:10.
- R7: When atten bit 3 is 1, the override command ends after the settling delay with no TX accesses.
- R8: The disable command reads the RX status once and writes that value, with bit 14 cleared, to RX override.
- R9: When lane_mapped is low, the override and disable commands raise done in the cycle after the command and make no access. The retry loop still issues its hard-reset requests.
- R10: The retry command runs attempts made of disable, a hr_req/hr_done handshake, and override. After each attempt it stops if link_det is 0, if link_online is 1, or if RETRY_MAX+1 attempts have been made.
- R11: done is a one-cycle pulse at the end of each command. Commands that arrive while busy is high are ignored. When commands arrive together, the retry command wins over override, and override wins over disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_override | input | 1 | Start the override sequence |
| cmd_disable | input | 1 | Start the RX override clear |
| cmd_hreset | input | 1 | Start the hard-reset retry loop |
| lane | input | LANE_W | Lane index inside the PHY |
| lane_mapped | input | 1 | A PHY is present for this lane |
| atten | input | 4 | TX attenuation; bit 3 skips the TX step |
| link_det | input | 2 | Device detection field of the link status |
| link_online | input | 1 | Link is up |
| hr_done | input | 1 | Hard reset finished |
| hr_req | output | 1 | Hard reset request, held until hr_done |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| busy | output | 1 | A command is running |
| done | output | 1 | Command completed (one-cycle pulse) |

## Verification
The hardest cases to reach from the ports are the exhausted half-rate poll and the exhausted retry budget. Each needs a status that never changes, and with the real limits that would take thousands of accesses. The bench builds the design with small POLL_MAX and RETRY_MAX values. Its register model keeps the half-rate bit set for a programmable number of status reads, and one vector keeps it set past the poll limit. A hard-reset responder always reports a present but offline link, so the loop has to run out its budget.

// File: rtl/phy_ovr_pkg.sv
package phy_ovr_pkg;
  localparam logic [15:0] TX_STAT_A = 16'h2001;
  localparam logic [15:0] RX_STAT_A = 16'h2002;
  localparam logic [15:0] TX_OVR_A  = 16'h2004;
  localparam logic [15:0] RX_OVR_A  = 16'h2005;
  localparam int HALF_BIT  = 0;
  localparam int DPLL_LSB  = 8;
  localparam int ATT_LSB   = 10;
  localparam int DPLL_RST  = 11;
  localparam int RX_OVR_EN = 14;
  localparam int TX_OVR_EN = 15;

  typedef enum logic [3:0] {
    E_IDLE, E_POLL, E_RX_RD, E_RX_WR, E_SETTLE,
    E_TX_RD, E_TX_WR, E_DIS_RD, E_DIS_WR, E_FIN
  } eng_state_t;

  typedef enum logic [2:0] {
    R_IDLE, R_DIS_GO, R_DIS_WT, R_HR, R_OVR_GO, R_OVR_WT, R_EVAL, R_FIN
  } rty_state_t;

  function automatic logic [15:0] lane_addr(logic [15:0] base,
                                            logic [15:0] lane16,
                                            logic [15:0] stride);
    return base + lane16 * stride;
  endfunction

  // Value written to RX override at a given step of the ordered sequence
  function automatic logic [15:0] rx_word(logic [15:0] tmp, logic [2:0] step,
                                          logic [2:0] mode);
    logic [15:0] w;
    w = tmp;
    w[RX_OVR_EN] = (step >= 3'd1);
    if (step >= 3'd2) w[DPLL_LSB+2:DPLL_LSB] = mode;
    if (step == 3'd3) w[DPLL_RST] = 1'b1;
    if (step == 3'd4) w[DPLL_RST] = 1'b0;
    return w;
  endfunction

  function automatic logic [15:0] tx_word(logic [15:0] tmp, logic [2:0] step,
                                          logic [2:0] att);
    logic [15:0] w;
    w = tmp;
    w[TX_OVR_EN] = (step >= 3'd1);
    if (step >= 3'd2) w[ATT_LSB+2:ATT_LSB] = w[ATT_LSB+2:ATT_LSB] | att;
    return w;
  endfunction
endpackage

// File: rtl/phy_ovr_engine.sv
module phy_ovr_engine
  import phy_ovr_pkg::*;
#(
  parameter int          LANE_W      = 2,
  parameter logic [15:0] LANE_STRIDE = 16'h0100,
  parameter int          POLL_MAX    = 1000,
  parameter int          SETTLE_CYC  = 1500000,
  parameter logic [2:0]  DPLL_MODE   = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ovr,
  input  logic              go_dis,
  input  logic [LANE_W-1:0] lane,
  input  logic              lane_mapped,
  input  logic [3:0]        atten,
  output logic              reg_req,
  output logic              reg_we,
  output logic [15:0]       reg_addr,
  output logic [15:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [15:0]       reg_rdata,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(SETTLE_CYC + POLL_MAX + 2);

  eng_state_t        state;
  logic [2:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic [15:0]       tmp;
  logic [LANE_W-1:0] lane_q;
  logic [3:0]        att_q;
  logic              mapped_q;

  wire xfer     = reg_req & reg_ack;
  wire settling = (state == E_SETTLE);
  wire polling  = (state == E_POLL);
  wire [15:0] lane16 = 16'(lane_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= E_IDLE; step <= '0; cnt <= '0; tmp <= '0;
      lane_q <= '0; att_q <= '0; mapped_q <= 1'b0;
    end else begin
      case (state)
        E_IDLE: if (go_ovr || go_dis) begin
          lane_q <= lane; att_q <= atten; mapped_q <= lane_mapped; cnt <= '0;
          if (!lane_mapped) state <= E_FIN;
          else state <= go_ovr ? E_POLL : E_DIS_RD;
        end
        E_POLL: if (xfer) begin
          if (reg_rdata[HALF_BIT] && cnt < CNT_W'(POLL_MAX - 1)) cnt <= cnt + 1'b1;
          else state <= E_RX_RD;
        end
        E_RX_RD: if (xfer) begin tmp <= reg_rdata; step <= '0; state <= E_RX_WR; end
        E_RX_WR: if (xfer) begin
          if (step == 3'd4) begin state <= E_SETTLE; cnt <= '0; end
          else step <= step + 1'b1;
        end
        E_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) state <= att_q[3] ? E_FIN : E_TX_RD;
          else cnt <= cnt + 1'b1;
        end
        E_TX_RD: if (xfer) begin tmp <= reg_rdata; step <= '0; state <= E_TX_WR; end
        E_TX_WR: if (xfer) begin
          if (step == 3'd2) state <= E_FIN;
          else step <= step + 1'b1;
        end
        E_DIS_RD: if (xfer) begin tmp <= reg_rdata; state <= E_DIS_WR; end
        E_DIS_WR: if (xfer) state <= E_FIN;
        default:  state <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req   = 1'b1;
    reg_we    = 1'b0;
    reg_addr  = lane_addr(RX_STAT_A, lane16, LANE_STRIDE);
    reg_wdata = '0;
    case (state)
      E_POLL, E_RX_RD, E_DIS_RD: ;
      E_RX_WR: begin
        reg_we = 1'b1; reg_addr = lane_addr(RX_OVR_A, lane16, LANE_STRIDE);
        reg_wdata = rx_word(tmp, step, DPLL_MODE);
      end
      E_DIS_WR: begin
        reg_we = 1'b1; reg_addr = lane_addr(RX_OVR_A, lane16, LANE_STRIDE);
        reg_wdata = rx_word(tmp, 3'd0, DPLL_MODE);
      end
      E_TX_RD: reg_addr = lane_addr(TX_STAT_A, lane16, LANE_STRIDE);
      E_TX_WR: begin
        reg_we = 1'b1; reg_addr = lane_addr(TX_OVR_A, lane16, LANE_STRIDE);
        reg_wdata = tx_word(tmp, step, att_q[2:0]);
      end
      default: begin reg_req = 1'b0; reg_addr = '0; end
    endcase
  end

  assign busy = (state != E_IDLE);
  assign done = (state == E_FIN);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    polling |-> cnt < CNT_W'(POLL_MAX));
  p_quiet_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> !reg_req);
  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mapped_q |-> !reg_req);
endmodule

// File: rtl/phy_retry_ctl.sv
module phy_retry_ctl
  import phy_ovr_pkg::*;
#(
  parameter int RETRY_MAX = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       eng_done,
  input  logic [1:0] link_det,
  input  logic       link_online,
  input  logic       hr_done,
  output logic       go_dis,
  output logic       go_ovr,
  output logic       hr_req,
  output logic       busy,
  output logic       fin
);
  localparam int ATT_W = $clog2(RETRY_MAX + 2);

  rty_state_t       state;
  logic [ATT_W-1:0] tries;

  wire no_device = (link_det == 2'b00);
  wire budget_out = (tries == ATT_W'(RETRY_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= R_IDLE; tries <= '0;
    end else begin
      case (state)
        R_IDLE:   if (go) begin state <= R_DIS_GO; tries <= '0; end
        R_DIS_GO: state <= R_DIS_WT;
        R_DIS_WT: if (eng_done) state <= R_HR;
        R_HR:     if (hr_done) state <= R_OVR_GO;
        R_OVR_GO: state <= R_OVR_WT;
        R_OVR_WT: if (eng_done) state <= R_EVAL;
        R_EVAL: begin
          if (no_device || link_online || budget_out) state <= R_FIN;
          else begin tries <= tries + 1'b1; state <= R_DIS_GO; end
        end
        default: state <= R_IDLE;
      endcase
    end
  end

  assign go_dis = (state == R_DIS_GO);
  assign go_ovr = (state == R_OVR_GO);
  assign hr_req = (state == R_HR);
  assign busy   = (state != R_IDLE);
  assign fin    = (state == R_FIN);

  p_retry_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= ATT_W'(RETRY_MAX));
  p_hr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hr_req && !hr_done |=> hr_req);
endmodule

// File: rtl/phy_lane_seq.sv
module phy_lane_seq
  import phy_ovr_pkg::*;
#(
  parameter int          LANE_W      = 2,
  parameter logic [15:0] LANE_STRIDE = 16'h0100,
  parameter int          POLL_MAX    = 1000,
  parameter int          SETTLE_CYC  = 1500000,
  parameter int          RETRY_MAX   = 100,
  parameter logic [2:0]  DPLL_MODE   = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_override,
  input  logic              cmd_disable,
  input  logic              cmd_hreset,
  input  logic [LANE_W-1:0] lane,
  input  logic              lane_mapped,
  input  logic [3:0]        atten,
  input  logic [1:0]        link_det,
  input  logic              link_online,
  input  logic              hr_done,
  output logic              hr_req,
  output logic              reg_req,
  output logic              reg_we,
  output logic [15:0]       reg_addr,
  output logic [15:0]       reg_wdata,
  input  logic              reg_ack,
  input  logic [15:0]       reg_rdata,
  output logic              busy,
  output logic              done
);
  logic eng_busy, eng_done, rc_busy, rc_fin, rc_dis, rc_ovr;

  wire idle    = !eng_busy && !rc_busy;
  wire ext_hr  = idle && cmd_hreset;
  wire ext_ovr = idle && !cmd_hreset && cmd_override;
  wire ext_dis = idle && !cmd_hreset && !cmd_override && cmd_disable;

  phy_ovr_engine #(
    .LANE_W(LANE_W), .LANE_STRIDE(LANE_STRIDE), .POLL_MAX(POLL_MAX),
    .SETTLE_CYC(SETTLE_CYC), .DPLL_MODE(DPLL_MODE)
  ) u_eng (
    .clk(clk), .rst_n(rst_n),
    .go_ovr(rc_ovr | ext_ovr), .go_dis(rc_dis | ext_dis),
    .lane(lane), .lane_mapped(lane_mapped), .atten(atten),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .busy(eng_busy), .done(eng_done)
  );

  phy_retry_ctl #(.RETRY_MAX(RETRY_MAX)) u_rty (
    .clk(clk), .rst_n(rst_n), .go(ext_hr), .eng_done(eng_done),
    .link_det(link_det), .link_online(link_online), .hr_done(hr_done),
    .go_dis(rc_dis), .go_ovr(rc_ovr), .hr_req(hr_req),
    .busy(rc_busy), .fin(rc_fin)
  );

  assign busy = eng_busy | rc_busy;
  assign done = rc_fin | (eng_done & !rc_busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hr_only_loop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hr_req |-> !eng_busy);
endmodule

// File: tb/phy_lane_seq_test.sv
module phy_lane_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 4;
  localparam int SETTLE = 20;
  localparam int RETRY = 3;
  localparam int NVEC = 5;
  // {lane[2], atten[4], halfrate_reads[4], rx_status[16], tx_status[16]}
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd0, 4'd5, 4'd0,  16'h0000, 16'h0000},
    {2'd1, 4'd2, 4'd2,  16'hB8F0, 16'hFC3C},
    {2'd3, 4'd8, 4'd10, 16'h4A52, 16'h1234},
    {2'd2, 4'd7, 4'd1,  16'hFFFE, 16'hFFFF},
    {2'd0, 4'd0, 4'd3,  16'h0802, 16'h8000}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_override = 0, cmd_disable = 0, cmd_hreset = 0;
  logic [1:0] lane = 0;
  logic lane_mapped = 1;
  logic [3:0] atten = 0;
  logic [1:0] link_det = 0;
  logic link_online = 0;
  logic hr_done = 0, hr_req;
  logic reg_req, reg_we, reg_ack = 0;
  logic [15:0] reg_addr, reg_wdata, reg_rdata = 0;
  logic busy, done;

  int checks = 0, errors = 0, cyc = 0;
  int rx_reads = 0, hr_n = 0, hr_cnt = 0, nlog = 0, ne = 0;
  logic [15:0] rx_val = 0, tx_val = 0;
  logic [15:0] la [64]; logic lw [64]; logic [15:0] ld [64]; int lc [64];
  logic [15:0] ea [64]; logic ew [64]; logic [15:0] ed [64];

  phy_lane_seq #(.POLL_MAX(POLL), .SETTLE_CYC(SETTLE), .RETRY_MAX(RETRY)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_override(cmd_override), .cmd_disable(cmd_disable),
    .cmd_hreset(cmd_hreset), .lane(lane), .lane_mapped(lane_mapped), .atten(atten),
    .link_det(link_det), .link_online(link_online), .hr_done(hr_done), .hr_req(hr_req),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rx_stat_at(logic [1:0] l); return 16'h2002 + {6'd0, l, 8'd0}; endfunction
  function automatic logic [15:0] tx_stat_at(logic [1:0] l); return 16'h2001 + {6'd0, l, 8'd0}; endfunction

  // register model and hard-reset responder
  always @(posedge clk) begin
    if (!rst_n) begin reg_ack <= 0; hr_done <= 0; end
    else begin
      hr_done <= hr_req && !hr_done;
      if (reg_req && !reg_ack) begin
        reg_ack <= 1;
        if (!reg_we && reg_addr == rx_stat_at(lane)) begin
          reg_rdata <= rx_val | {15'd0, rx_reads < hr_n};
          rx_reads = rx_reads + 1;
        end else if (!reg_we && reg_addr == tx_stat_at(lane)) reg_rdata <= tx_val;
        else reg_rdata <= 16'hDEAD;
      end else reg_ack <= 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (reg_req && reg_ack) begin
      if (nlog < 64) begin la[nlog] = reg_addr; lw[nlog] = reg_we; ld[nlog] = reg_wdata; lc[nlog] = cyc; end
      nlog++;
    end
    if (hr_req && hr_done) hr_cnt++;
    if (cyc == 150000) begin
      errors++; $display("FAIL watchdog: run hung, actual cyc=%0d expected done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic put(logic [15:0] a, logic w, logic [15:0] d);
    ea[ne] = a; ew[ne] = w; ed[ne] = d; ne++;
  endtask

  // R3 R4 R6 R7 expected access list, written from the requirement text
  task automatic build_ovr(logic [1:0] l, logic [3:0] at, int hrn, logic [15:0] rx, logic [15:0] tx);
    int p; logic [15:0] s, v;
    ne = 0;
    p = (hrn < POLL) ? hrn + 1 : POLL;
    for (int i = 0; i < p; i++) put(rx_stat_at(l), 0, 0);
    put(rx_stat_at(l), 0, 0);
    s = rx | {15'd0, p < hrn};
    v = s & 16'hBFFF;               put(rx_stat_at(l) + 3, 1, v);
    v = v | 16'h4000;               put(rx_stat_at(l) + 3, 1, v);
    v = (v & 16'hF8FF) | 16'h0300;  put(rx_stat_at(l) + 3, 1, v);
    v = v | 16'h0800;               put(rx_stat_at(l) + 3, 1, v);
    v = v & 16'hF7FF;               put(rx_stat_at(l) + 3, 1, v);
    if (!at[3]) begin
      put(tx_stat_at(l), 0, 0);
      v = tx & 16'h7FFF;            put(tx_stat_at(l) + 3, 1, v);
      v = v | 16'h8000;             put(tx_stat_at(l) + 3, 1, v);
      v = v | {3'd0, at[2:0], 10'd0}; put(tx_stat_at(l) + 3, 1, v);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " access count"}, nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      chk({tag, " addr"}, la[i], ea[i]);
      chk({tag, " we"}, lw[i], ew[i]);
      if (ew[i]) chk({tag, " wdata"}, ld[i], ed[i]);
    end
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    nlog = 0; rx_reads = 0; hr_cnt = 0;
    cmd_override = (which == 0); cmd_disable = (which == 1); cmd_hreset = (which == 2);
    if (which == 3) begin cmd_override = 1; cmd_disable = 1; end
    @(negedge clk);
    cmd_override = 0; cmd_disable = 0; cmd_hreset = 0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, done, 1);
    @(negedge clk);
    chk({tag, " done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reg_req after reset", reg_req, 0);
    chk("R1 hr_req after reset", hr_req, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: table of override vectors
    for (int k = 0; k < NVEC; k++) begin
      logic [41:0] v; int p;
      v = VEC[k];
      lane = v[41:40]; atten = v[39:36]; hr_n = int'(v[35:32]);
      rx_val = v[31:16]; tx_val = v[15:0];
      build_ovr(lane, atten, hr_n, rx_val, tx_val);
      pulse(0);
      wait_done($sformatf("R4 vec%0d", k));
      compare($sformatf("R3/R4/R6/R7 vec%0d", k));
      p = (hr_n < POLL) ? hr_n + 1 : POLL;
      if (!atten[3] && nlog > p + 6) begin
        checks++;
        if (lc[p+6] - lc[p+5] < SETTLE + 1 || lc[p+6] - lc[p+5] > SETTLE + 3) begin
          errors++; $display("FAIL R5 settle gap actual=%0d expected=%0d", lc[p+6] - lc[p+5], SETTLE + 2);
        end
      end
    end

    // R8 disable command
    lane = 2; rx_val = 16'h7FF0; hr_n = 0;
    ne = 0; put(16'h2202, 0, 0); put(16'h2205, 1, 16'h3FF0);
    pulse(1); wait_done("R8 disable"); compare("R8 disable");

    // R9 unmapped lane: immediate done, no accesses
    lane_mapped = 0; atten = 0;
    pulse(0);
    chk("R9 unmapped override done", done, 1);
    @(negedge clk); chk("R9 unmapped override accesses", nlog, 0);
    pulse(1);
    chk("R9 unmapped disable done", done, 1);
    @(negedge clk); chk("R9 unmapped disable accesses", nlog, 0);
    link_det = 0; link_online = 0;
    pulse(2); wait_done("R9 unmapped retry");
    chk("R9 unmapped retry hr count", hr_cnt, 1);
    chk("R9 unmapped retry accesses", nlog, 0);
    lane_mapped = 1;

    // R10 retry loop exits
    lane = 1; atten = 4'd8; rx_val = 16'h0100; hr_n = 0;
    link_det = 2'd0; link_online = 0;
    pulse(2); wait_done("R10 no device");
    chk("R10 no device attempts", hr_cnt, 1);
    chk("R10 no device accesses", nlog, 9);
    link_det = 2'd3; link_online = 1;
    pulse(2); wait_done("R10 online");
    chk("R10 online attempts", hr_cnt, 1);
    link_det = 2'd1; link_online = 0;
    pulse(2); wait_done("R10 budget");
    chk("R10 budget attempts", hr_cnt, RETRY + 1);
    chk("R10 budget accesses", nlog, 9 * (RETRY + 1));

    // R11 ignore while busy, and priority
    lane = 0; atten = 4'd8; rx_val = 16'h0000; hr_n = 0;
    pulse(0);
    chk("R11 busy during override", busy, 1);
    @(negedge clk); cmd_disable = 1; @(negedge clk); cmd_disable = 0;
    wait_done("R11 ignore");
    build_ovr(0, 4'd8, 0, 16'h0000, 16'h0000);
    chk("R11 command ignored while busy", nlog, ne);
    @(negedge clk); chk("R11 idle after ignored command", busy, 0);
    pulse(3); wait_done("R11 priority");
    chk("R11 override wins over disable", nlog, ne);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule